// File: doc/BRIEF.md
# Parallel Port Byte Receiver (Peripheral Side)

This block is the peripheral end of an 8-bit compatibility-mode parallel printer link. The host puts a byte on the data lines and pulls the active-low strobe low. The receiver passes the strobe through a synchroniser and raises BUSY as soon as it sees the falling edge. It rejects strobe pulses that stay low for fewer cycles than a configured minimum. When a strobe is accepted, the receiver latches the byte and writes it into a small receive FIFO. It then drives an active-low acknowledge pulse of fixed length and drops BUSY when that pulse ends. If the FIFO is full, the handshake waits with BUSY high and no acknowledge until the consumer pops an entry.

Three status outputs are registered from internal inputs: paper empty, select and fault. Select is also gated by the host's select-in line. The host initialise line can be enabled or disabled by configuration. When it is enabled, holding it low empties the FIFO and returns the handshake to idle. The consumer reads bytes through a show-ahead port with a valid flag and a pop strobe.

Handshake states: IDLE waits for a synchronised strobe fall and goes to QUAL. QUAL counts low cycles. It returns to IDLE if the strobe rises early, which is a glitch. It goes to PUSH once the count reaches the minimum, and it latches the byte on that transition. PUSH writes the byte when the FIFO has space, goes to ACK, and otherwise stays in PUSH. ACK holds the acknowledge low for ACK_CYC cycles and then goes to IDLE. From any state, an enabled and asserted init moves the handshake to FLUSH. FLUSH returns to IDLE once init is released.

Top module: `pport_rx`

## Requirements
- R1: After reset, hst_busy is 0, hst_ack_n is 1, rd_valid is 0 and hst_fault_n is 1.
- R2: A falling edge on hst_stb_n raises hst_busy within 5 clock cycles. If the strobe stays low long enough to be accepted, the byte on hst_data is stored in the FIFO.
- R3: Each stored byte produces exactly one hst_ack_n low pulse of exactly ACK_CYC cycles, and never before the byte is written. hst_busy stays 1 during the pulse and is 0 in the cycle hst_ack_n returns to 1.
- R4: A strobe low for clearly fewer than cfg_min_stb cycles stores nothing and gives no acknowledge, and hst_busy returns to 0. A value of 0 in cfg_min_stb acts as 1.
- R5: Bytes leave the FIFO in arrival order. rd_data shows the oldest byte whenever rd_valid is 1, and rd_en pops it.
- R6: With the FIFO full (FIFO_DEPTH entries), an accepted strobe keeps hst_busy at 1 and gives no acknowledge until an entry is popped. The byte is then stored and acknowledged.
- R7: With cfg_init_en at 1, hst_init_n low empties the FIFO and forces the handshake to idle with hst_busy 0, even during an acknowledge. After release, transfers resume normally.
- R8: With cfg_init_en at 0, hst_init_n has no effect: stored bytes stay readable in order.
- R9: hst_pe follows st_paper_out. hst_sel is st_online AND (hst_selin_n low). hst_fault_n is the inverse of st_fault. Each settles within 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_stb_n | input | 1 | Host data strobe, active low, asynchronous |
| hst_data | input | 8 | Host data lines |
| hst_init_n | input | 1 | Host initialise request, active low, asynchronous |
| hst_selin_n | input | 1 | Host select-in, active low, asynchronous |
| hst_busy | output | 1 | Busy to host |
| hst_ack_n | output | 1 | Acknowledge pulse to host, active low |
| hst_pe | output | 1 | Paper-empty status to host |
| hst_sel | output | 1 | Selected/online status to host |
| hst_fault_n | output | 1 | Fault status to host, active low |
| cfg_init_en | input | 1 | 1 lets the host initialise line flush and reset the handshake |
| cfg_min_stb | input | 8 | Minimum accepted strobe low time in clock cycles |
| st_paper_out | input | 1 | Internal paper-out condition |
| st_online | input | 1 | Internal online condition |
| st_fault | input | 1 | Internal fault condition |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest byte in the FIFO |
| rd_valid | output | 1 | FIFO holds at least one byte |

## Verification
The properties assume that the configuration inputs stay static while a handshake is in progress. They also assume the host holds the data lines stable from before the strobe fall until the byte is latched. The acknowledge-width check expects every pulse to run its full length unless an enabled init cuts it short. The stimulus changes configuration only while BUSY is low and holds data from its 0.5 µs setup until the handshake returns to idle. It uses strobe widths far above or far below the glitch threshold, never near it.

// File: rtl/pport_pkg.sv
package pport_pkg;

    typedef enum logic [2:0] {
        HS_IDLE  = 3'd0,
        HS_QUAL  = 3'd1,
        HS_PUSH  = 3'd2,
        HS_ACK   = 3'd3,
        HS_FLUSH = 3'd4
    } hs_state_t;

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pport_fifo.sv
module pport_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   level;
    logic          do_push, do_pop;

    assign full    = (level == (AW+1)'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + (AW+1)'(1);
                2'b01:   level <= level - (AW+1)'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/pport_hs_fsm.sv
module pport_hs_fsm
    import pport_pkg::*;
#(
    parameter int W       = 8,
    parameter int FILT_W  = 8,
    parameter int ACK_CYC = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_s,
    input  logic              init_act,
    input  logic [FILT_W-1:0] min_stb,
    input  logic [W-1:0]      pdata,
    input  logic              fifo_full,
    output logic              push,
    output logic [W-1:0]      push_data,
    output logic              busy,
    output logic              ack_n
);
    localparam int ACK_W = (ACK_CYC > 1) ? $clog2(ACK_CYC) : 1;

    hs_state_t         state, nxt;
    logic              stb_prev;
    logic              stb_fall;
    logic [FILT_W-1:0] filt_cnt;
    logic [FILT_W-1:0] min_eff;
    logic [ACK_W-1:0]  ack_cnt;
    logic [W-1:0]      byte_q;

    assign stb_fall  = stb_prev && !stb_s;
    assign min_eff   = (min_stb == '0) ? FILT_W'(1) : min_stb;
    assign push_data = byte_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            HS_IDLE:  if (stb_fall) nxt = HS_QUAL;
            HS_QUAL: begin
                if (stb_s)                   nxt = HS_IDLE;
                else if (filt_cnt >= min_eff) nxt = HS_PUSH;
            end
            HS_PUSH:  if (!fifo_full) nxt = HS_ACK;
            HS_ACK:   if (ack_cnt == ACK_W'(ACK_CYC - 1)) nxt = HS_IDLE;
            HS_FLUSH: nxt = HS_IDLE;
            default:  nxt = HS_IDLE;
        endcase
        if (init_act) nxt = HS_FLUSH;
    end

    // counters and byte latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_prev <= 1'b1;
            filt_cnt <= '0;
            ack_cnt  <= '0;
            byte_q   <= '0;
        end else begin
            stb_prev <= stb_s;
            if (state == HS_QUAL) filt_cnt <= filt_cnt + FILT_W'(1);
            else                  filt_cnt <= FILT_W'(1);
            if (state == HS_ACK)  ack_cnt <= ack_cnt + ACK_W'(1);
            else                  ack_cnt <= '0;
            if (state == HS_QUAL && nxt == HS_PUSH) byte_q <= pdata;
        end
    end

    // outputs
    always_comb begin
        busy  = 1'b0;
        ack_n = 1'b1;
        push  = 1'b0;
        unique case (state)
            HS_IDLE:  ;
            HS_QUAL:  busy = 1'b1;
            HS_PUSH: begin
                busy = 1'b1;
                push = !fifo_full && !init_act;
            end
            HS_ACK: begin
                busy  = 1'b1;
                ack_n = 1'b0;
            end
            HS_FLUSH: ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/pport_rx.sv
module pport_rx #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int FILT_W     = 8,
    parameter int ACK_CYC    = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_stb_n,
    input  logic [DATA_W-1:0] hst_data,
    input  logic              hst_init_n,
    input  logic              hst_selin_n,
    output logic              hst_busy,
    output logic              hst_ack_n,
    output logic              hst_pe,
    output logic              hst_sel,
    output logic              hst_fault_n,
    input  logic              cfg_init_en,
    input  logic [FILT_W-1:0] cfg_min_stb,
    input  logic              st_paper_out,
    input  logic              st_online,
    input  logic              st_fault,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [2:0]        sync_q;
    logic              stb_s, init_s, selin_s;
    logic              init_act;
    logic              hs_push;
    logic [DATA_W-1:0] hs_byte;
    logic              ff_full, ff_empty;

    pport_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hst_stb_n, hst_init_n, hst_selin_n}),
        .q     (sync_q)
    );
    assign {stb_s, init_s, selin_s} = sync_q;
    assign init_act = cfg_init_en && !init_s;

    pport_hs_fsm #(.W(DATA_W), .FILT_W(FILT_W), .ACK_CYC(ACK_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_s     (stb_s),
        .init_act  (init_act),
        .min_stb   (cfg_min_stb),
        .pdata     (hst_data),
        .fifo_full (ff_full),
        .push      (hs_push),
        .push_data (hs_byte),
        .busy      (hst_busy),
        .ack_n     (hst_ack_n)
    );

    pport_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (init_act),
        .push  (hs_push),
        .din   (hs_byte),
        .pop   (rd_en),
        .dout  (rd_data),
        .empty (ff_empty),
        .full  (ff_full)
    );
    assign rd_valid = !ff_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hst_pe      <= 1'b0;
            hst_sel     <= 1'b0;
            hst_fault_n <= 1'b1;
        end else begin
            hst_pe      <= st_paper_out;
            hst_sel     <= st_online && !selin_s;
            hst_fault_n <= !st_fault;
        end
    end
endmodule

// File: rtl/pport_rx_chk.sv
module pport_rx_chk #(
    parameter int ACK_CYC = 250
) (
    input logic clk,
    input logic rst_n,
    input logic hst_busy,
    input logic hst_ack_n,
    input logic rd_valid,
    input logic hs_push,
    input logic ff_full,
    input logic ff_empty,
    input logic init_act
);
    int unsigned ack_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ack_lo <= 0;
        else if (!hst_ack_n) ack_lo <= ack_lo + 1;
        else                 ack_lo <= 0;
    end

    // R3: acknowledge only inside a busy handshake
    p_ack_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_ack_n |-> hst_busy);

    // R3: acknowledge starts only after a FIFO write
    p_ack_after_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hst_ack_n) |-> $past(hs_push));

    // R3: pulse never longer than ACK_CYC, full length unless init cut it
    p_ack_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_lo <= ACK_CYC);
    p_ack_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hst_ack_n) && !$past(init_act)) |-> ack_lo == ACK_CYC);

    // R2: a write leaves the FIFO non-empty
    p_push_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_push && !init_act) |=> !ff_empty);

    // R6: no acknowledge begins while the FIFO was full
    p_ack_needs_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hst_ack_n) |-> !$past(ff_full));

    // R7: enabled init leaves the port idle and empty
    p_init_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_act |=> (!hst_busy && !rd_valid));
endmodule

bind pport_rx pport_rx_chk #(.ACK_CYC(ACK_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_busy  (hst_busy),
    .hst_ack_n (hst_ack_n),
    .rd_valid  (rd_valid),
    .hs_push   (hs_push),
    .ff_full   (ff_full),
    .ff_empty  (ff_empty),
    .init_act  (init_act)
);

// File: tb/pport_rx_test.sv
`timescale 1ns/1ps
module pport_rx_test;
    localparam int ACK_CYC = 250;
    localparam int DEPTH   = 4;
    localparam int SETUP   = 125;
    localparam int LOWMIN  = 125;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hst_stb_n = 1'b1;
    logic [7:0] hst_data = 8'h00;
    logic       hst_init_n = 1'b1;
    logic       hst_selin_n = 1'b1;
    logic       hst_busy, hst_ack_n, hst_pe, hst_sel, hst_fault_n;
    logic       cfg_init_en = 1'b0;
    logic [7:0] cfg_min_stb = 8'd20;
    logic       st_paper_out = 1'b0, st_online = 1'b0, st_fault = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int n_chk = 0, n_fail = 0;
    int ack_count = 0, ack_cur = 0, ack_last = 0;
    logic busy_at_ack_end = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;

    pport_rx #(.FIFO_DEPTH(DEPTH), .ACK_CYC(ACK_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .hst_stb_n(hst_stb_n), .hst_data(hst_data),
        .hst_init_n(hst_init_n), .hst_selin_n(hst_selin_n), .hst_busy(hst_busy),
        .hst_ack_n(hst_ack_n), .hst_pe(hst_pe), .hst_sel(hst_sel),
        .hst_fault_n(hst_fault_n), .cfg_init_en(cfg_init_en),
        .cfg_min_stb(cfg_min_stb), .st_paper_out(st_paper_out),
        .st_online(st_online), .st_fault(st_fault), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // acknowledge monitor
    always @(negedge clk) begin
        if (rst_n && !hst_ack_n) ack_cur++;
        else if (ack_cur > 0) begin
            ack_last = ack_cur;
            ack_count++;
            busy_at_ack_end = hst_busy;
            ack_cur = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!hst_busy && hst_ack_n) break;
            @(negedge clk);
        end
        cycles(2);
    endtask

    task automatic strobe(input logic [7:0] b, input int low);
        @(negedge clk);
        hst_data = b;
        cycles(SETUP);
        hst_stb_n = 1'b0;
        cycles(5);
        check(hst_busy == 1'b1, "R2 busy after strobe fall", hst_busy, 1);
        cycles(low - 5);
        hst_stb_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] b);
        strobe(b, LOWMIN);
        wait_idle();
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string tag);
        @(negedge clk);
        check(rd_valid == 1'b1, tag, rd_valid, 1);
        check(rd_data == exp, tag, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        check(hst_busy == 1'b0, "R1 busy", hst_busy, 0);
        check(hst_ack_n == 1'b1, "R1 ack_n", hst_ack_n, 1);
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        check(hst_fault_n == 1'b1, "R1 fault_n", hst_fault_n, 1);
    endtask

    task automatic t_single();
        int a0 = ack_count;
        send(8'hA5);
        check(ack_count == a0 + 1, "R3 one ack", ack_count - a0, 1);
        check(ack_last == ACK_CYC, "R3 ack width", ack_last, ACK_CYC);
        check(busy_at_ack_end == 1'b0, "R3 busy drops with ack", busy_at_ack_end, 0);
        check(rd_valid && rd_data == 8'hA5, "R2 byte stored", rd_data, 8'hA5);
    endtask

    task automatic t_glitch();
        int a0 = ack_count;
        strobe(8'hEE, 8);
        cycles(60);
        check(ack_count == a0, "R4 no ack on glitch", ack_count - a0, 0);
        check(hst_busy == 1'b0, "R4 busy released", hst_busy, 0);
    endtask

    task automatic t_order();
        send(8'h3C);
        send(8'h5A);
        send(8'hF0);
        pop_expect(8'hA5, "R5 order 0 (R4 no glitch byte)");
        pop_expect(8'h3C, "R5 order 1");
        pop_expect(8'h5A, "R5 order 2");
        pop_expect(8'hF0, "R5 order 3");
        @(negedge clk);
        check(rd_valid == 1'b0, "R5 drained", rd_valid, 0);
    endtask

    task automatic t_full();
        int a0;
        send(8'h11); send(8'h22); send(8'h33); send(8'h44);
        a0 = ack_count;
        strobe(8'h55, LOWMIN);
        cycles(600);
        check(hst_busy == 1'b1, "R6 busy held when full", hst_busy, 1);
        check(ack_count == a0 && hst_ack_n, "R6 ack withheld", ack_count - a0, 0);
        pop_expect(8'h11, "R6 pop frees space");
        wait_idle();
        check(ack_count == a0 + 1, "R6 ack after space", ack_count - a0, 1);
        pop_expect(8'h22, "R6 drain");
        pop_expect(8'h33, "R6 drain");
        pop_expect(8'h44, "R6 drain");
        pop_expect(8'h55, "R6 stalled byte kept");
    endtask

    task automatic t_init_en();
        cfg_init_en = 1'b1;
        send(8'h61); send(8'h62);
        hst_init_n = 1'b0;
        cycles(10);
        check(rd_valid == 1'b0, "R7 FIFO flushed", rd_valid, 1'b0);
        hst_init_n = 1'b1;
        cycles(5);
        strobe(8'h63, LOWMIN);
        for (int i = 0; i < 400; i++) begin
            if (!hst_ack_n) break;
            @(negedge clk);
        end
        cycles(20);
        hst_init_n = 1'b0;
        cycles(6);
        check(hst_busy == 1'b0, "R7 busy low during init", hst_busy, 0);
        check(hst_ack_n == 1'b1, "R7 ack ended by init", hst_ack_n, 1);
        check(rd_valid == 1'b0, "R7 mid-ack flush", rd_valid, 0);
        hst_init_n = 1'b1;
        cycles(5);
        send(8'h64);
        pop_expect(8'h64, "R7 resumes after init");
    endtask

    task automatic t_init_dis();
        cfg_init_en = 1'b0;
        send(8'h77);
        hst_init_n = 1'b0;
        cycles(10);
        hst_init_n = 1'b1;
        cycles(5);
        pop_expect(8'h77, "R8 init ignored");
    endtask

    task automatic t_status();
        st_paper_out = 1'b1; st_online = 1'b1; st_fault = 1'b1; hst_selin_n = 1'b0;
        cycles(5);
        check(hst_pe == 1'b1, "R9 pe", hst_pe, 1);
        check(hst_sel == 1'b1, "R9 sel", hst_sel, 1);
        check(hst_fault_n == 1'b0, "R9 fault_n", hst_fault_n, 0);
        hst_selin_n = 1'b1; st_paper_out = 1'b0;
        cycles(5);
        check(hst_sel == 1'b0, "R9 sel needs selin", hst_sel, 0);
        check(hst_pe == 1'b0, "R9 pe clear", hst_pe, 0);
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_single();
        t_glitch();
        t_order();
        t_full();
        t_init_en();
        t_init_dis();
        t_status();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule